// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns an 18-bit virtual address into a 20-bit physical address. The two top address bits pick one of four segments, and each segment owns a small linear page table. A segment is described by a base (the slot in a shared 64-entry page-table store where its table starts) and a bound (how many pages it spans). The page number inside the segment is checked against the bound. If it is in range, the table entry is read and checked for presence and for permission to do the requested access. A request produces exactly one of three results: a physical address, a segmentation fault or a protection fault.

Software loads the page-table store and the per-segment base and bound through a configuration port. Typically segment 0 holds code mapped read/execute and segment 1 holds heap mapped read/write. Segments 2 and 3 are free for any use. Requests may arrive on every cycle. Each result comes out with a valid strobe two clock edges after the request is sampled.

Top module: `segpt_xlate`

## Requirements
- R1: The virtual address splits into segment bits [17:16], page number bits [15:12] and offset bits [11:0]. A successful translation returns `rsp_pa = {pfn, offset}`, with both fault flags low.
- R2: A page number greater than or equal to the selected segment's bound gives `rsp_segfault=1`, `rsp_protfault=0` and `rsp_pa=0`, whatever the table store holds.
- R3: After reset every segment has bound zero, so every request faults with a segmentation fault until a bound is written.
- R4: A table entry whose valid bit is clear gives a segmentation fault and `rsp_pa=0`.
- R5: Access type 0 (read) needs the r bit, type 1 (write) needs the w bit and type 2 (execute) needs the x bit. Type 3 is always refused. A refused access on a valid, in-bound entry gives `rsp_protfault=1`, `rsp_segfault=0` and `rsp_pa=0`.
- R6: The table-store index is the segment base plus the page number, modulo 64. A table may therefore wrap from slot 63 to slot 0.
- R7: No more than one fault flag is high in any cycle. Both flags and `rsp_pa` are zero whenever `rsp_valid` is low.
- R8: A request sampled with `req_valid` high at clock edge N yields `rsp_valid` high after edge N+2. Back-to-back requests give back-to-back results in order, one per request.
- R9: A table entry is 12 bits: PFN in [11:4], valid in [3], r in [2], w in [1], x in [0]. It is written with `cfg_pte_we`, `cfg_pte_idx` and `cfg_pte_data`.
- R10: `cfg_seg_we` writes `cfg_seg_base` (6 bits) and `cfg_seg_bound` (5 bits, 0 to 16) into the segment chosen by `cfg_seg_sel`. The new values apply to requests sampled from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_pte_we | input | 1 | Write strobe for the page-table store |
| cfg_pte_idx | input | 6 | Table-store slot to write |
| cfg_pte_data | input | 12 | Table entry {pfn, valid, r, w, x} |
| cfg_seg_we | input | 1 | Write strobe for a segment's base and bound |
| cfg_seg_sel | input | 2 | Segment to configure |
| cfg_seg_base | input | 6 | Starting slot of the segment's table |
| cfg_seg_bound | input | 5 | Number of pages in the segment |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 18 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Result strobe |
| rsp_pa | output | 20 | Physical address; zero on a fault |
| rsp_segfault | output | 1 | Bound violation or entry not valid |
| rsp_protfault | output | 1 | Access not permitted by the entry |

## Verification
Each result is due two edges after its request is sampled. In the first edge the bound check is registered and the table store is read. In the second edge the decision is registered onto the outputs. The bench drives inputs on the falling edge and carries its expected results through a two-deep delay line. On each falling edge it compares the outputs with the prediction made two falling edges earlier, so back-to-back streams and idle gaps are checked cycle by cycle. Configuration writes are made only while the pipeline is empty, which keeps each prediction tied to the table contents in force when its request was sampled.

// File: rtl/segpt_pkg.sv
package segpt_pkg;

    localparam int VA_W       = 18;
    localparam int SEG_W      = 2;
    localparam int VPN_W      = 4;
    localparam int OFF_W      = 12;
    localparam int PFN_W      = 8;
    localparam int PTE_DEPTH  = 64;

    localparam int NUM_SEGS   = 2 ** SEG_W;
    localparam int PTE_AW     = $clog2(PTE_DEPTH);
    localparam int BOUND_W    = VPN_W + 1;
    localparam int PA_W       = PFN_W + OFF_W;
    localparam int SEG_LSB    = OFF_W + VPN_W;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             valid;
        logic             r;
        logic             w;
        logic             x;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef struct packed {
        logic [PTE_AW-1:0]  base;
        logic [BOUND_W-1:0] bound;
    } seg_cfg_t;

    typedef struct packed {
        logic             over;
        acc_e             acc;
        logic [OFF_W-1:0] off;
    } xl_stage_t;

    function automatic logic acc_allowed(input pte_t e, input acc_e a);
        case (a)
            ACC_READ:  return e.r;
            ACC_WRITE: return e.w;
            ACC_EXEC:  return e.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/segpt_seg_table.sv
module segpt_seg_table
    import segpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [SEG_W-1:0]   wsel,
    input  logic [PTE_AW-1:0]  wbase,
    input  logic [BOUND_W-1:0] wbound,
    input  logic [SEG_W-1:0]   rsel,
    output seg_cfg_t           rcfg
);

    seg_cfg_t cfg_q [NUM_SEGS];

    for (genvar g = 0; g < NUM_SEGS; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[g] <= '0;
            end else if (we && (wsel == SEG_W'(g))) begin
                cfg_q[g].base  <= wbase;
                cfg_q[g].bound <= wbound;
            end
        end
    end

    assign rcfg = cfg_q[rsel];

    a_r3_bound_cleared: assert property (@(posedge clk)
        disable iff (rst) $past(rst) |-> (rcfg.bound == '0));

endmodule

// File: rtl/segpt_pte_mem.sv
module segpt_pte_mem
    import segpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTE_AW-1:0] waddr,
    input  pte_t              wdata,
    input  logic [PTE_AW-1:0] raddr,
    output pte_t              rdata
);

    pte_t mem [PTE_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PTE_DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end

    a_r9_write_lands: assert property (@(posedge clk)
        disable iff (rst) we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/segpt_perm_check.sv
module segpt_perm_check
    import segpt_pkg::*;
(
    input  pte_t             pte,
    input  xl_stage_t        st,
    output logic [PA_W-1:0]  pa,
    output logic             seg_f,
    output logic             prot_f
);

    always_comb begin
        pa     = '0;
        seg_f  = 1'b0;
        prot_f = 1'b0;
        if (st.over || !pte.valid) begin
            seg_f = 1'b1;
        end else if (!acc_allowed(pte, st.acc)) begin
            prot_f = 1'b1;
        end else begin
            pa = {pte.pfn, st.off};
        end
    end

endmodule

// File: rtl/segpt_xlate.sv
module segpt_xlate
    import segpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_pte_we,
    input  logic [PTE_AW-1:0]  cfg_pte_idx,
    input  logic [PTE_W-1:0]   cfg_pte_data,
    input  logic               cfg_seg_we,
    input  logic [SEG_W-1:0]   cfg_seg_sel,
    input  logic [PTE_AW-1:0]  cfg_seg_base,
    input  logic [BOUND_W-1:0] cfg_seg_bound,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_acc,
    output logic               rsp_valid,
    output logic [PA_W-1:0]    rsp_pa,
    output logic               rsp_segfault,
    output logic               rsp_protfault
);

    logic [SEG_W-1:0]  va_seg;
    logic [VPN_W-1:0]  va_vpn;
    seg_cfg_t          cur_cfg;
    logic [PTE_AW-1:0] pte_idx;
    xl_stage_t         st_d, st_q;
    logic              s1_valid;
    pte_t              pte_q;
    logic [PA_W-1:0]   chk_pa;
    logic              chk_seg, chk_prot;

    assign va_seg = req_va[VA_W-1:SEG_LSB];
    assign va_vpn = req_va[SEG_LSB-1:OFF_W];

    segpt_seg_table i_seg_table (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_seg_we),
        .wsel   (cfg_seg_sel),
        .wbase  (cfg_seg_base),
        .wbound (cfg_seg_bound),
        .rsel   (va_seg),
        .rcfg   (cur_cfg)
    );

    assign pte_idx = cur_cfg.base + PTE_AW'(va_vpn);

    segpt_pte_mem i_pte_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_pte_we),
        .waddr (cfg_pte_idx),
        .wdata (pte_t'(cfg_pte_data)),
        .raddr (pte_idx),
        .rdata (pte_q)
    );

    always_comb begin
        st_d.over = ({1'b0, va_vpn} >= cur_cfg.bound);
        st_d.acc  = acc_e'(req_acc);
        st_d.off  = req_va[OFF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            st_q     <= '0;
        end else begin
            s1_valid <= req_valid;
            st_q     <= st_d;
        end
    end

    segpt_perm_check i_perm_check (
        .pte    (pte_q),
        .st     (st_q),
        .pa     (chk_pa),
        .seg_f  (chk_seg),
        .prot_f (chk_prot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_pa        <= '0;
            rsp_segfault  <= 1'b0;
            rsp_protfault <= 1'b0;
        end else begin
            rsp_valid     <= s1_valid;
            rsp_pa        <= s1_valid ? chk_pa : '0;
            rsp_segfault  <= s1_valid & chk_seg;
            rsp_protfault <= s1_valid & chk_prot;
        end
    end

    a_r7_one_fault: assert property (@(posedge clk)
        disable iff (rst) !(rsp_segfault && rsp_protfault));

    a_r7_quiet_idle: assert property (@(posedge clk)
        disable iff (rst) !rsp_valid |-> (!rsp_segfault && !rsp_protfault && rsp_pa == '0));

    a_r8_latency: assert property (@(posedge clk)
        disable iff (rst) req_valid |-> ##2 rsp_valid);

    a_r1_offset_kept: assert property (@(posedge clk)
        disable iff (rst) (rsp_valid && !rsp_segfault && !rsp_protfault)
            |-> (rsp_pa[OFF_W-1:0] == $past(req_va[OFF_W-1:0], 2)));

    a_r2_fault_zero_pa: assert property (@(posedge clk)
        disable iff (rst) (rsp_segfault || rsp_protfault) |-> (rsp_pa == '0));

endmodule

// File: tb/test_segpt_xlate.sv
module test_segpt_xlate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_pte_we = 1'b0;
    logic [5:0]  cfg_pte_idx = '0;
    logic [11:0] cfg_pte_data = '0;
    logic        cfg_seg_we = 1'b0;
    logic [1:0]  cfg_seg_sel = '0;
    logic [5:0]  cfg_seg_base = '0;
    logic [4:0]  cfg_seg_bound = '0;
    logic        req_valid = 1'b0;
    logic [17:0] req_va = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [19:0] rsp_pa;
    logic        rsp_segfault;
    logic        rsp_protfault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [5:0]  m_base  [4];
    logic [4:0]  m_bound [4];
    logic [11:0] m_pte   [64];

    logic        d1_v = 0, d2_v = 0;
    logic [21:0] d1_e = '0, d2_e = '0;
    string       d1_t = "", d2_t = "";

    always #10 clk = ~clk;

    segpt_xlate i_segpt_xlate (
        .clk(clk), .rst(rst),
        .cfg_pte_we(cfg_pte_we), .cfg_pte_idx(cfg_pte_idx), .cfg_pte_data(cfg_pte_data),
        .cfg_seg_we(cfg_seg_we), .cfg_seg_sel(cfg_seg_sel),
        .cfg_seg_base(cfg_seg_base), .cfg_seg_bound(cfg_seg_bound),
        .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa),
        .rsp_segfault(rsp_segfault), .rsp_protfault(rsp_protfault)
    );

    // expected {segfault, protfault, pa}
    function automatic logic [21:0] model(input logic [17:0] va, input logic [1:0] acc);
        logic [1:0]  s;
        logic [3:0]  v;
        logic [5:0]  idx;
        logic [11:0] p;
        logic        ok;
        s = va[17:16];
        v = va[15:12];
        if ({1'b0, v} >= m_bound[s]) return {2'b10, 20'h0};   // R2, R3
        idx = m_base[s] + {2'b00, v};                          // R6
        p = m_pte[idx];                                        // R9 layout
        if (!p[3]) return {2'b10, 20'h0};                      // R4
        case (acc)                                             // R5
            2'd0: ok = p[2];
            2'd1: ok = p[1];
            2'd2: ok = p[0];
            default: ok = 1'b0;
        endcase
        if (!ok) return {2'b01, 20'h0};
        return {2'b00, p[11:4], va[11:0]};                     // R1
    endfunction

    task automatic check(input string tag, input bit cond, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [17:0] va, input logic [1:0] acc, input string tag);
        @(negedge clk);
        if (d2_v || rsp_valid) begin
            check({tag_or(d2_t), " R8 valid strobe"}, rsp_valid == d2_v, 32'(rsp_valid), 32'(d2_v));
            if (d2_v) begin
                check(d2_t, {rsp_segfault, rsp_protfault, rsp_pa} == d2_e,
                      32'({rsp_segfault, rsp_protfault, rsp_pa}), 32'(d2_e));
                check("R7 single fault flag", !(rsp_segfault && rsp_protfault),
                      32'({rsp_segfault, rsp_protfault}), 32'(d2_e[21:20]));
            end
        end else begin
            check("R7 idle outputs quiet", {rsp_segfault, rsp_protfault, rsp_pa} == 22'h0,
                  32'({rsp_segfault, rsp_protfault, rsp_pa}), 32'h0);
        end
        d2_v = d1_v; d2_e = d1_e; d2_t = d1_t;
        d1_v = v;    d1_e = v ? model(va, acc) : 22'h0; d1_t = tag;
        req_valid = v; req_va = va; req_acc = acc;
    endtask

    function automatic string tag_or(input string t);
        return (t == "") ? "idle" : t;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, "");
    endtask

    task automatic wr_pte(input logic [5:0] idx, input logic [11:0] d);
        @(negedge clk);
        cfg_pte_we = 1'b1; cfg_pte_idx = idx; cfg_pte_data = d;
        @(posedge clk); #1;
        cfg_pte_we = 1'b0;
        m_pte[idx] = d;
    endtask

    task automatic wr_seg(input logic [1:0] s, input logic [5:0] b, input logic [4:0] bd);
        @(negedge clk);
        cfg_seg_we = 1'b1; cfg_seg_sel = s; cfg_seg_base = b; cfg_seg_bound = bd;
        @(posedge clk); #1;
        cfg_seg_we = 1'b0;
        m_base[s] = b; m_bound[s] = bd;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'h5eed);
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_bound[i] = '0; end
        for (int i = 0; i < 64; i++) m_pte[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R7 reset outputs", {rsp_valid, rsp_segfault, rsp_protfault, rsp_pa} == 23'h0,
              32'({rsp_valid, rsp_segfault, rsp_protfault, rsp_pa}), 32'h0);

        // R3: bounds are zero after reset
        step(1'b1, 18'h00000, 2'd0, "R3 seg0 after reset");
        step(1'b1, 18'h1F123, 2'd1, "R3 seg1 after reset");
        step(1'b1, 18'h3A456, 2'd2, "R3 seg3 after reset");
        idle(2);

        // R9: fill table with random entries
        for (int i = 0; i < 64; i++) wr_pte(6'(i), 12'($urandom));
        // code segment r-x
        wr_pte(6'd0, {8'h10, 4'b1101});
        wr_pte(6'd1, {8'h15, 4'b1101});
        wr_pte(6'd2, {8'h12, 4'b1101});
        // heap segment rw-, slot 11 invalid
        wr_pte(6'd8,  {8'h22, 4'b1110});
        wr_pte(6'd9,  {8'h02, 4'b1110});
        wr_pte(6'd10, {8'h04, 4'b1110});
        wr_pte(6'd11, {8'h77, 4'b0111});
        // R10: segment config
        wr_seg(2'd0, 6'd0,  5'd3);
        wr_seg(2'd1, 6'd8,  5'd4);
        wr_seg(2'd2, 6'd60, 5'd16);
        wr_seg(2'd3, 6'd20, 5'd0);
        idle(2);

        // directed cases
        step(1'b1, 18'h02FFF, 2'd2, "R1 code exec page 2");
        step(1'b1, 18'h00ABC, 2'd0, "R1 code read page 0");
        step(1'b1, 18'h01ABC, 2'd1, "R5 write to code page");
        step(1'b1, 18'h10FFF, 2'd1, "R1 heap write page 0");
        step(1'b1, 18'h11111, 2'd2, "R5 exec on heap page");
        step(1'b1, 18'h12345, 2'd3, "R5 reserved access type");
        step(1'b1, 18'h03000, 2'd0, "R2 code page at bound");
        step(1'b1, 18'h1F000, 2'd0, "R2 heap page past bound");
        step(1'b1, 18'h13000, 2'd0, "R4 invalid heap entry");
        step(1'b1, 18'h24001, 2'd0, "R6 wrap slot 0");
        step(1'b1, 18'h23002, 2'd1, "R6 slot 63");
        step(1'b1, 18'h2F003, 2'd2, "R6 wrap slot 11");
        step(1'b1, 18'h30000, 2'd0, "R3 bound zero segment");
        idle(1);
        step(1'b1, 18'h00010, 2'd0, "R8 after gap");
        idle(2);

        // R10: rebinding a segment takes effect
        wr_seg(2'd3, 6'd8, 5'd2);
        idle(2);
        step(1'b1, 18'h31010, 2'd0, "R10 rebound seg3");
        step(1'b1, 18'h32010, 2'd0, "R10 seg3 new bound");
        idle(2);

        // random stream, back to back
        for (int i = 0; i < 400; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, 18'($urandom), 2'($urandom % 4), "R8 random stream");
        end
        idle(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule